// File: doc/BRIEF.md
# Count-Register Branch Resolver

This unit sits in the branch stage of a 64-bit core and settles conditional branches that may depend on the count register (CTR). Each accepted request carries several pieces of information: the branch kind, five option bits, the condition-register bit under test, a 32-bit narrow-mode flag and a model capability flag. The unit then decides whether the branch is taken. It also produces the target address, updates CTR and flags an invalid instruction form. CTR lives inside the unit. A separate write port loads it, serving move-to-count-register traffic.

An ordinary conditional branch with the count option decrements CTR first and then tests the new value. The branch-to-count-register form with the count option behaves in one of two ways. On a capable model, the old CTR value is both the jump target and the tested value, and CTR is decremented afterwards. On any other model, the form raises an invalid-form exception and leaves CTR alone. All results appear one clock after the request strobe.

Top module: `ctr_branch_resolver`

## Requirements
- R1: A request seen on `reqValid` at a rising edge gives `resValid` high for exactly the following cycle. `taken`, `target` and `invalidForm` are valid with it. `resValid` is low in every cycle that does not follow a request.
- R2: While `rstN` is low, `ctrOut` is zero and `resValid`, `taken` and `invalidForm` are low.
- R3: `ctrWrEn` without a request loads `ctrWrData` into CTR, and `ctrOut` shows it the next cycle. If a request arrives in the same cycle, the request's CTR update wins and the write is dropped.
- R4: With `boBits[2]`=1 the count option is off: CTR is unchanged and plays no part in the decision.
- R5: For the ordinary form (`kindToCtr`=0) with `boBits[2]`=0, CTR is decremented by one (modulo 2^64, so 0 becomes all ones) and the new value is tested. With `boBits[1]`=1 the count test passes when that value is zero; with `boBits[1]`=0 it passes when the value is nonzero.
- R6: With `narrowMode`=1, only bits 31:0 of the tested value are compared with zero. The full 64-bit CTR is still decremented.
- R7: For `kindToCtr`=1 with `boBits[2]`=0 and `ctrCapable`=1, the pre-update CTR value is tested with the rule of R5/R6 and used as the target. CTR is then decremented by one.
- R8: For `kindToCtr`=1 with `boBits[2]`=0 and `ctrCapable`=0, `invalidForm` goes high, `taken` is low, `target` is zero and CTR is unchanged.
- R9: With `boBits[0]`=1 the condition-register test is ignored. Otherwise it passes when `crBit` equals `boBits[3]`. `taken` is high only when both the count test (if active) and the condition-register test pass.
- R10: For `kindToCtr`=0 the target is `immTarget`. For `kindToCtr`=1, where R8 does not apply, it is the pre-update CTR with bits 1:0 forced to zero.
- R11: `invalidForm` is cleared by the next request that is not an invalid form. Otherwise it holds its value between requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Branch request strobe |
| kindToCtr | input | 1 | 1 = branch-to-count-register form, 0 = relative/absolute form |
| boBits | input | 5 | Branch option bits (bit0 CR-test off, bit1 test-for-zero, bit2 count off, bit3 wanted CR value) |
| crBit | input | 1 | Condition-register bit selected for this branch |
| narrowMode | input | 1 | 32-bit mode: zero test uses bits 31:0 only |
| ctrCapable | input | 1 | Model supports the count option on the to-CTR form |
| immTarget | input | 64 | Target for the relative/absolute form |
| ctrWrEn | input | 1 | CTR write strobe |
| ctrWrData | input | 64 | CTR write value |
| resValid | output | 1 | Result strobe, one cycle after a request |
| taken | output | 1 | Branch taken |
| target | output | 64 | Branch target address |
| invalidForm | output | 1 | Invalid-form exception |
| ctrOut | output | 64 | Current CTR value |

## Verification
The bench targets the ordering difference between the two forms. For a CTR value of 1 with the test-for-zero option, an ordinary branch is taken while the to-CTR form is not; a design that tests the wrong side of the decrement swaps these outcomes. Narrow-mode cases use values whose low half is zero but whose high half is not, which exposes a full-width comparison. Decrements from zero expose a missing wrap. The invalid-form case on a non-capable model checks that CTR is unchanged, so a design that decrements anyway is caught. Two further cases check that a same-cycle write is dropped and that a disabled count option leaves CTR untouched.

// File: rtl/ctr_branch_pkg.sv
package ctr_branch_pkg;

  // Positions inside the branch option field
  localparam int unsigned BO_W      = 5;
  localparam int unsigned BO_CR_OFF = 0;  // 1: ignore condition-register test
  localparam int unsigned BO_EQZ    = 1;  // 1: count test wants zero
  localparam int unsigned BO_NOCNT  = 2;  // 1: count option off
  localparam int unsigned BO_CRVAL  = 3;  // wanted condition-register value

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;     // request accepted this cycle
    logic decCtr;      // write CTR-1
    logic loadCtr;     // write external value
    logic tgtFromCtr;  // target sourced from pre-update CTR
    logic zeroTgt;     // force target to zero
    logic takeNow;     // branch decision
    logic raiseInval;  // invalid-form exception
  } dpStrobes_t;

endpackage

// File: rtl/ctr_branch_dp.sv
module ctr_branch_dp
  import ctr_branch_pkg::*;
#(
  parameter int unsigned XLEN      = 64,
  parameter int unsigned NARROWLEN = 32,
  parameter int unsigned ALIGNBITS = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpStrobes_t      strb,
  input  logic            narrowMode,
  input  logic [XLEN-1:0] immTarget,
  input  logic [XLEN-1:0] ctrWrData,
  output logic            zeroPre,
  output logic            zeroPost,
  output logic            resValid,
  output logic            taken,
  output logic            invalidForm,
  output logic [XLEN-1:0] target,
  output logic [XLEN-1:0] ctrOut
);

  logic [XLEN-1:0] ctrQ;
  logic [XLEN-1:0] ctrDec;
  logic [XLEN-1:0] ctrNext;
  logic [XLEN-1:0] tgtNext;
  logic            preLowZero, preHighZero;
  logic            postLowZero, postHighZero;

  assign ctrDec = ctrQ - XLEN'(1);

  // Zero detection split into low and high halves so narrow mode can mask the upper half
  assign preLowZero  = (ctrQ[NARROWLEN-1:0] == '0);
  assign postLowZero = (ctrDec[NARROWLEN-1:0] == '0);

  generate
    if (XLEN > NARROWLEN) begin : g_highHalf
      assign preHighZero  = (ctrQ[XLEN-1:NARROWLEN] == '0);
      assign postHighZero = (ctrDec[XLEN-1:NARROWLEN] == '0);
    end else begin : g_noHigh
      assign preHighZero  = 1'b1;
      assign postHighZero = 1'b1;
    end
  endgenerate

  assign zeroPre  = preLowZero  && (narrowMode || preHighZero);
  assign zeroPost = postLowZero && (narrowMode || postHighZero);

  always_comb begin
    if (strb.decCtr)       ctrNext = ctrDec;
    else if (strb.loadCtr) ctrNext = ctrWrData;
    else                   ctrNext = ctrQ;
  end

  always_comb begin
    if (strb.zeroTgt)         tgtNext = '0;
    else if (strb.tgtFromCtr) tgtNext = {ctrQ[XLEN-1:ALIGNBITS], ALIGNBITS'(0)};
    else                      tgtNext = immTarget;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrQ        <= '0;
      resValid    <= 1'b0;
      taken       <= 1'b0;
      invalidForm <= 1'b0;
      target      <= '0;
    end else begin
      ctrQ     <= ctrNext;
      resValid <= strb.capture;
      if (strb.capture) begin
        taken       <= strb.takeNow;
        invalidForm <= strb.raiseInval;
        target      <= tgtNext;
      end else begin
        taken <= 1'b0;
      end
    end
  end

  assign ctrOut = ctrQ;

endmodule

// File: rtl/ctr_branch_ctrl.sv
module ctr_branch_ctrl
  import ctr_branch_pkg::*;
(
  input  logic             reqValid,
  input  logic             kindToCtr,
  input  logic [BO_W-1:0]  boBits,
  input  logic             crBit,
  input  logic             ctrCapable,
  input  logic             ctrWrEn,
  input  logic             zeroPre,
  input  logic             zeroPost,
  output dpStrobes_t       strb
);

  logic countOn;
  logic illegal;
  logic testedZero;
  logic countOk;
  logic crOk;

  assign countOn    = !boBits[BO_NOCNT];
  assign illegal    = kindToCtr && countOn && !ctrCapable;
  // to-CTR form tests the value before the update, ordinary form the value after it
  assign testedZero = kindToCtr ? zeroPre : zeroPost;
  assign countOk    = !countOn || (testedZero == boBits[BO_EQZ]);
  assign crOk       = boBits[BO_CR_OFF] || (crBit == boBits[BO_CRVAL]);

  always_comb begin
    strb            = '0;
    strb.capture    = reqValid;
    strb.decCtr     = reqValid && countOn && !illegal;
    strb.loadCtr    = ctrWrEn && !reqValid;
    strb.tgtFromCtr = kindToCtr;
    strb.zeroTgt    = illegal;
    strb.takeNow    = !illegal && countOk && crOk;
    strb.raiseInval = illegal;
  end

endmodule

// File: rtl/ctr_branch_resolver.sv
module ctr_branch_resolver
  import ctr_branch_pkg::*;
#(
  parameter int unsigned XLEN      = 64,
  parameter int unsigned NARROWLEN = 32,
  parameter int unsigned ALIGNBITS = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic            kindToCtr,
  input  logic [4:0]      boBits,
  input  logic            crBit,
  input  logic            narrowMode,
  input  logic            ctrCapable,
  input  logic [XLEN-1:0] immTarget,
  input  logic            ctrWrEn,
  input  logic [XLEN-1:0] ctrWrData,
  output logic            resValid,
  output logic            taken,
  output logic [XLEN-1:0] target,
  output logic            invalidForm,
  output logic [XLEN-1:0] ctrOut
);

  dpStrobes_t strb;
  logic       zeroPre;
  logic       zeroPost;

  ctr_branch_ctrl u_ctrl (
    .reqValid   (reqValid),
    .kindToCtr  (kindToCtr),
    .boBits     (boBits),
    .crBit      (crBit),
    .ctrCapable (ctrCapable),
    .ctrWrEn    (ctrWrEn),
    .zeroPre    (zeroPre),
    .zeroPost   (zeroPost),
    .strb       (strb)
  );

  ctr_branch_dp #(
    .XLEN      (XLEN),
    .NARROWLEN (NARROWLEN),
    .ALIGNBITS (ALIGNBITS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .narrowMode  (narrowMode),
    .immTarget   (immTarget),
    .ctrWrData   (ctrWrData),
    .zeroPre     (zeroPre),
    .zeroPost    (zeroPost),
    .resValid    (resValid),
    .taken       (taken),
    .invalidForm (invalidForm),
    .target      (target),
    .ctrOut      (ctrOut)
  );

endmodule

// File: rtl/ctr_branch_chk.sv
module ctr_branch_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            kindToCtr,
  input logic [4:0]      boBits,
  input logic            ctrCapable,
  input logic            ctrWrEn,
  input logic            resValid,
  input logic            taken,
  input logic [XLEN-1:0] target,
  input logic            invalidForm,
  input logic [XLEN-1:0] ctrOut
);

  p_req_gives_result_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> resValid);

  p_idle_no_result_r1: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !resValid);

  p_count_off_keeps_ctr_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && boBits[2]) |=> (ctrOut == $past(ctrOut)));

  p_plain_decrement_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !boBits[2] && !kindToCtr) |=> (ctrOut == $past(ctrOut) - XLEN'(1)));

  p_capable_decrement_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !boBits[2] && kindToCtr && ctrCapable) |=> (ctrOut == $past(ctrOut) - XLEN'(1)));

  p_invalid_no_take_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !boBits[2] && kindToCtr && !ctrCapable) |=> (invalidForm && !taken && ctrOut == $past(ctrOut)));

  p_ctr_target_aligned_r10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && kindToCtr) |=> (target[1:0] == 2'b00));

  p_write_loads_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrWrEn && !reqValid) |=> !invalidForm || $past(invalidForm));

endmodule

bind ctr_branch_resolver ctr_branch_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .kindToCtr   (kindToCtr),
  .boBits      (boBits),
  .ctrCapable  (ctrCapable),
  .ctrWrEn     (ctrWrEn),
  .resValid    (resValid),
  .taken       (taken),
  .target      (target),
  .invalidForm (invalidForm),
  .ctrOut      (ctrOut)
);

// File: tb/ctr_branch_resolver_tb.sv
module ctr_branch_resolver_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        kindToCtr = 1'b0;
  logic [4:0]  boBits = '0;
  logic        crBit = 1'b0;
  logic        narrowMode = 1'b0;
  logic        ctrCapable = 1'b0;
  logic [63:0] immTarget = '0;
  logic        ctrWrEn = 1'b0;
  logic [63:0] ctrWrData = '0;
  logic        resValid, taken, invalidForm;
  logic [63:0] target, ctrOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct {
    logic        eTaken;
    logic [63:0] eTarget;
    logic        eInval;
    logic [63:0] eCtr;
    string       tag;
  } expItem_t;

  expItem_t scoreQ[$];
  logic [63:0] mCtr = '0;

  always #10 clk = ~clk;  // 50 MHz

  ctr_branch_resolver u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .kindToCtr(kindToCtr),
    .boBits(boBits), .crBit(crBit), .narrowMode(narrowMode), .ctrCapable(ctrCapable),
    .immTarget(immTarget), .ctrWrEn(ctrWrEn), .ctrWrData(ctrWrData),
    .resValid(resValid), .taken(taken), .target(target),
    .invalidForm(invalidForm), .ctrOut(ctrOut)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic zeroTest(input logic [63:0] v, input logic nar);
    return nar ? (v[31:0] == 32'd0) : (v == 64'd0);
  endfunction

  // Driver: drives one request and queues the expected result
  task automatic issue(input logic toCtr, input logic [4:0] bo, input logic cr,
                       input logic nar, input logic cap, input logic [63:0] imm,
                       input logic wr, input logic [63:0] wrVal, input string tag);
    expItem_t it;
    logic cntOn, bad_form, tv, cntOk, crOk;
    logic [63:0] newCtr;
    @(negedge clk);
    reqValid = 1'b1; kindToCtr = toCtr; boBits = bo; crBit = cr;
    narrowMode = nar; ctrCapable = cap; immTarget = imm;
    ctrWrEn = wr; ctrWrData = wrVal;
    cntOn    = !bo[2];
    bad_form = toCtr && cntOn && !cap;
    newCtr   = (cntOn && !bad_form) ? mCtr - 64'd1 : mCtr;
    tv       = toCtr ? zeroTest(mCtr, nar) : zeroTest(newCtr, nar);
    cntOk    = !cntOn || (tv == bo[1]);
    crOk     = bo[0] || (cr == bo[3]);
    it.eTaken  = !bad_form && cntOk && crOk;
    it.eTarget = bad_form ? 64'd0 : (toCtr ? {mCtr[63:2], 2'b00} : imm);
    it.eInval  = bad_form;
    it.eCtr    = newCtr;
    it.tag     = tag;
    mCtr       = newCtr;
    scoreQ.push_back(it);
    @(negedge clk);
    reqValid = 1'b0; ctrWrEn = 1'b0;
  endtask

  task automatic ctrWrite(input logic [63:0] v);
    @(negedge clk);
    ctrWrEn = 1'b1; ctrWrData = v;
    @(negedge clk);
    ctrWrEn = 1'b0;
    mCtr = v;
    chk(ctrOut == v, "R3 write load", ctrOut, v);
    chk(resValid == 1'b0, "R1 no result after write", 64'(resValid), 64'd0);
  endtask

  // Monitor: compares results as they appear
  always @(negedge clk) begin
    if (rstN && resValid) begin
      if (scoreQ.size() == 0) begin
        chk(1'b0, "R1 unexpected result", 64'd1, 64'd0);
      end else begin
        expItem_t e;
        e = scoreQ.pop_front();
        chk(taken == e.eTaken, {e.tag, " taken"}, 64'(taken), 64'(e.eTaken));
        chk(target == e.eTarget, {e.tag, " target"}, target, e.eTarget);
        chk(invalidForm == e.eInval, {e.tag, " invalid"}, 64'(invalidForm), 64'(e.eInval));
        chk(ctrOut == e.eCtr, {e.tag, " ctr"}, ctrOut, e.eCtr);
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      chk(1'b0, "watchdog", 64'd0, 64'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] lf;
    repeat (3) @(negedge clk);
    // R2 reset state
    chk(ctrOut == 64'd0, "R2 ctr reset", ctrOut, 64'd0);
    chk(resValid == 1'b0, "R2 resValid reset", 64'(resValid), 64'd0);
    chk(invalidForm == 1'b0, "R2 invalid reset", 64'(invalidForm), 64'd0);
    chk(taken == 1'b0, "R2 taken reset", 64'(taken), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    ctrWrite(64'd5);
    issue(1'b0, 5'b00001, 1'b0, 1'b0, 1'b1, 64'h4000, 1'b0, '0, "R5 nonzero after dec");
    ctrWrite(64'd1);
    issue(1'b0, 5'b00011, 1'b0, 1'b0, 1'b1, 64'h4100, 1'b0, '0, "R5 zero after dec");
    ctrWrite(64'd1);
    issue(1'b0, 5'b00001, 1'b0, 1'b0, 1'b1, 64'h4200, 1'b0, '0, "R5 nonzero test fails");
    issue(1'b0, 5'b00001, 1'b0, 1'b0, 1'b1, 64'h4300, 1'b0, '0, "R5 wrap from zero");
    // R7 ordering: CTR=1 with zero test, to-CTR form sees 1 -> not taken
    ctrWrite(64'd1);
    issue(1'b1, 5'b00011, 1'b0, 1'b0, 1'b1, 64'h0, 1'b0, '0, "R7 old value tested");
    // R6 narrow mode
    ctrWrite(64'h1_0000_0001);
    issue(1'b0, 5'b00011, 1'b0, 1'b1, 1'b1, 64'h5000, 1'b0, '0, "R6 narrow low zero");
    ctrWrite(64'h1_0000_0001);
    issue(1'b0, 5'b00011, 1'b0, 1'b0, 1'b1, 64'h5000, 1'b0, '0, "R6 wide high nonzero");
    ctrWrite(64'hFFFF_FFFF_0000_0000);
    issue(1'b1, 5'b00011, 1'b0, 1'b1, 1'b1, 64'h0, 1'b0, '0, "R6 R7 narrow to-ctr");
    // R7 capable to-CTR
    ctrWrite(64'h1003);
    issue(1'b1, 5'b00001, 1'b0, 1'b0, 1'b1, 64'h0, 1'b0, '0, "R7 R10 to-ctr target");
    // R8 invalid then R11 clear
    ctrWrite(64'h2007);
    issue(1'b1, 5'b00001, 1'b0, 1'b0, 1'b0, 64'h0, 1'b0, '0, "R8 invalid form");
    @(negedge clk);
    chk(invalidForm == 1'b1, "R11 invalid holds", 64'(invalidForm), 64'd1);
    issue(1'b0, 5'b00101, 1'b0, 1'b0, 1'b0, 64'h6000, 1'b0, '0, "R11 invalid cleared");
    // R4 and R9: count off, CR test
    issue(1'b0, 5'b01100, 1'b1, 1'b0, 1'b1, 64'h7000, 1'b0, '0, "R4 R9 cr match");
    issue(1'b0, 5'b01100, 1'b0, 1'b0, 1'b1, 64'h7100, 1'b0, '0, "R4 R9 cr mismatch");
    issue(1'b0, 5'b00000, 1'b1, 1'b0, 1'b1, 64'h7200, 1'b0, '0, "R9 count ok cr fails");
    // R10 to-CTR without count, unaligned CTR
    ctrWrite(64'hABCD_0003);
    issue(1'b1, 5'b00101, 1'b0, 1'b0, 1'b0, 64'h0, 1'b0, '0, "R10 bcctr plain");
    // R3 same-cycle write dropped
    issue(1'b0, 5'b00001, 1'b0, 1'b0, 1'b1, 64'h8000, 1'b1, 64'h55, "R3 write dropped");
    @(negedge clk);
    chk(resValid == 1'b0, "R1 single pulse", 64'(resValid), 64'd0);

    // Mixed patterns
    lf = 64'hACE1_1234_5678_9ABD;
    for (int i = 0; i < 40; i++) begin
      lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
      if (i % 3 == 0) ctrWrite({lf[63:32], 30'd0, lf[1:0]});
      issue(lf[5], lf[10:6], lf[11], lf[12], lf[13], {lf[63:14], 14'd0},
            lf[14] & lf[15], lf, "R5 R7 R9 mixed");
    end
    repeat (3) @(negedge clk);
    chk(scoreQ.size() == 0, "R1 all results seen", 64'(scoreQ.size()), 64'd0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule